// File: doc/BRIEF.md
# FEAC Codeword Validator

This block sits behind the receive side of a DS3 channel that uses C-bit parity framing. An upstream stage extracts each Far-End Alarm and Control message and passes its 6-bit code here, with a one-cycle strobe per message. The block keeps the codes of the most recent messages in a sliding window. A code is accepted as valid once it dominates that window. The accepted code is dropped again once enough other codes have entered the window.

The accepted code stays readable on a dedicated output, and it remains there after the code is dropped. A byte-wide control/status view reports the following:

- the live valid flag;
- two sticky event flags, one for acceptance and one for dropping, each cleared by a read strobe;
- a software-writable enable bit for each event flag.

An interrupt line combines the enabled, pending events. The whole mechanism runs only while the C-bit mode input is high.

Top module: `feac_validator`

## Requirements
- R1: On a counted message, when the code is found in at least 8 of the last 10 counted messages (the new one included) and no code is currently accepted, that code becomes accepted and register bit 4 (valid flag) reads 1 after that clock edge.
- R2: While a code is accepted, a counted message that leaves at least 3 of the last 10 counted messages different from it drops it, and bit 4 then reads 0. With 2 or fewer differing messages the code stays accepted.
- R3: Window slots that have not yet received a message since reset match no code, so a single message never reaches either threshold on empty history.
- R4: `code_out` holds the most recently accepted code. It changes only on acceptance and keeps its value after the code is dropped.
- R5: Register bit 0 (accept event) becomes 1 on the edge where a code is accepted.
- R6: Register bit 2 (drop event) becomes 1 on the edge where the accepted code is dropped.
- R7: A cycle with `reg_rd` high clears bits 0 and 2 at its closing edge. If an event sets a bit on that same edge, the bit ends up 1.
- R8: Writes load bit 3 (drop event enable) and bit 1 (accept event enable). `irq` equals (bit0 AND bit1) OR (bit2 AND bit3).
- R9: While `cbit_mode` is low, message strobes are ignored: the window, the valid flag, the code and the event bits do not change.
- R10: After reset every register bit and `code_out` read 0. Bits 7 to 5 always read 0, and writes to bits 7 to 4, 2 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbit_mode | input | 1 | High when the channel runs C-bit parity framing |
| msg_stb | input | 1 | One-cycle strobe per received message |
| msg_code | input | 6 | Code carried by the message |
| reg_rd | input | 1 | Read strobe of the control/status register |
| reg_wr | input | 1 | Write strobe of the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control/status register view |
| code_out | output | 6 | Most recently accepted code |
| irq | output | 1 | Interrupt, enabled pending events |

## Verification
A directed run first exercises the empty history. It sends a single zero code, which must not be accepted if unfilled slots are correctly ignored. It then sends exactly seven and then eight identical codes, which separates an off-by-one acceptance threshold from a correct one. Next come two and then three differing codes, which pin the drop threshold. The run also lands an acceptance on the same edge as a read, to show that the set wins over the clear.

A seeded random phase follows. It mixes two dominant codes with stray codes, toggles the mode, and scatters reads and enable writes. This produces windows that hover near both thresholds, and a bench model of the window predicts every register value across them.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned WIN_LEN  = 10;
  localparam int unsigned ACC_MIN  = 8;
  localparam int unsigned DROP_MIN = 3;

  // register bit positions decoded by software
  localparam int unsigned B_ACC_EV  = 0;
  localparam int unsigned B_ACC_EN  = 1;
  localparam int unsigned B_DROP_EV = 2;
  localparam int unsigned B_DROP_EN = 3;
  localparam int unsigned B_VALID   = 4;

  typedef struct packed {
    logic drop_en;
    logic drop_ev;
    logic acc_en;
    logic acc_ev;
  } ctl_t;
endpackage

// File: rtl/feac_window.sv
module feac_window #(
  parameter int unsigned CW    = 6,
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic [CW-1:0]   new_code,
  input  logic [CW-1:0]   ref_code,
  output logic [CNTW-1:0] match_cnt,
  output logic [CNTW-1:0] fill_cnt
);
  localparam int unsigned KEEP = DEPTH - 1;

  logic [CW-1:0]    slot_q [KEEP];
  logic [KEEP-1:0]  used_q;
  logic [CW-1:0]    view   [DEPTH];
  logic [DEPTH-1:0] view_used;
  logic [DEPTH-1:0] hit;

  // view = window content after the incoming code is shifted in
  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    if (g == 0) begin : g_head
      assign view[g]      = new_code;
      assign view_used[g] = 1'b1;
    end else begin : g_tail
      assign view[g]      = slot_q[g-1];
      assign view_used[g] = used_q[g-1];
    end
    assign hit[g] = view_used[g] && (view[g] == ref_code);
  end

  always_comb begin
    match_cnt = '0;
    fill_cnt  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      match_cnt = match_cnt + CNTW'(hit[i]);
      fill_cnt  = fill_cnt + CNTW'(view_used[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < KEEP; i++) slot_q[i] <= '0;
    end else if (shift_en) begin
      used_q <= view_used[KEEP-1:0];
      for (int i = 0; i < KEEP; i++) slot_q[i] <= view[i];
    end
  end
endmodule

// File: rtl/feac_track.sv
module feac_track #(
  parameter int unsigned CW      = 6,
  parameter int unsigned CNTW    = 4,
  parameter int unsigned ACC_TH  = 8,
  parameter int unsigned DROP_TH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic [CW-1:0]   new_code,
  input  logic [CNTW-1:0] match_cnt,
  input  logic [CNTW-1:0] fill_cnt,
  output logic [CW-1:0]   ref_code,
  output logic            valid_q,
  output logic [CW-1:0]   code_q,
  output logic            set_acc,
  output logic            set_drop
);
  logic            valid_d;
  logic [CW-1:0]   code_d;
  logic [CNTW-1:0] miss_cnt;

  assign ref_code = valid_q ? code_q : new_code;
  assign miss_cnt = fill_cnt - match_cnt;

  always_comb begin
    valid_d  = valid_q;
    code_d   = code_q;
    set_acc  = 1'b0;
    set_drop = 1'b0;
    if (evt) begin
      if (valid_q) begin
        if (miss_cnt >= CNTW'(DROP_TH)) begin
          valid_d  = 1'b0;
          set_drop = 1'b1;
        end
      end else if (match_cnt >= CNTW'(ACC_TH)) begin
        valid_d = 1'b1;
        code_d  = new_code;
        set_acc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (evt) begin
      valid_q <= valid_d;
      code_q  <= code_d;
    end
  end
endmodule

// File: rtl/feac_csr.sv
module feac_csr
  import feac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       set_acc,
  input  logic       set_drop,
  input  logic       valid,
  output logic [7:0] rdata,
  output logic       irq
);
  ctl_t ctl_q, ctl_d;
  logic upd;

  assign upd = rd | wr | set_acc | set_drop;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.acc_en  = wdata[B_ACC_EN];
      ctl_d.drop_en = wdata[B_DROP_EN];
    end
    // read clears; an event on the same edge wins
    ctl_d.acc_ev  = (ctl_q.acc_ev  & ~rd) | set_acc;
    ctl_d.drop_ev = (ctl_q.drop_ev & ~rd) | set_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctl_q <= '0;
    else if (upd) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata            = '0;
    rdata[B_ACC_EV]  = ctl_q.acc_ev;
    rdata[B_ACC_EN]  = ctl_q.acc_en;
    rdata[B_DROP_EV] = ctl_q.drop_ev;
    rdata[B_DROP_EN] = ctl_q.drop_en;
    rdata[B_VALID]   = valid;
  end

  assign irq = (ctl_q.acc_ev & ctl_q.acc_en) | (ctl_q.drop_ev & ctl_q.drop_en);
endmodule

// File: rtl/feac_validator.sv
module feac_validator
  import feac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic              msg_stb,
  input  logic [CODE_W-1:0] msg_code,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [CODE_W-1:0] code_out,
  output logic              irq
);
  localparam int unsigned CNTW = $clog2(WIN_LEN + 1);

  logic              evt;
  logic [CODE_W-1:0] ref_code;
  logic [CNTW-1:0]   match_cnt;
  logic [CNTW-1:0]   fill_cnt;
  logic              valid;
  logic              set_acc;
  logic              set_drop;

  assign evt = msg_stb & cbit_mode;

  feac_window #(.CW(CODE_W), .DEPTH(WIN_LEN), .CNTW(CNTW)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(evt), .new_code(msg_code),
    .ref_code(ref_code), .match_cnt(match_cnt), .fill_cnt(fill_cnt)
  );

  feac_track #(.CW(CODE_W), .CNTW(CNTW), .ACC_TH(ACC_MIN), .DROP_TH(DROP_MIN)) u_trk (
    .clk(clk), .rst_n(rst_n), .evt(evt), .new_code(msg_code),
    .match_cnt(match_cnt), .fill_cnt(fill_cnt), .ref_code(ref_code),
    .valid_q(valid), .code_q(code_out), .set_acc(set_acc), .set_drop(set_drop)
  );

  feac_csr u_csr (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr), .wdata(reg_wdata),
    .set_acc(set_acc), .set_drop(set_drop), .valid(valid),
    .rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/feac_validator_chk.sv
module feac_validator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cbit_mode,
  input logic       msg_stb,
  input logic [5:0] code_out,
  input logic [7:0] reg_rdata,
  input logic       irq
);
  AST_IDLE_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_stb && cbit_mode) |=> $stable(reg_rdata[4]) && $stable(code_out)); // R9
  AST_CODE_FIXED_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |=> (!reg_rdata[4] || $stable(code_out))); // R4
  AST_ACCEPT_FLAGS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[4]) |-> reg_rdata[0]); // R5
  AST_DROP_FLAGS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[4]) |-> reg_rdata[2]); // R6
  AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((reg_rdata[0] && reg_rdata[1]) || (reg_rdata[2] && reg_rdata[3]))); // R8
  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000); // R10
endmodule

bind feac_validator feac_validator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .msg_stb(msg_stb),
  .code_out(code_out), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/feac_validator_test.sv
`timescale 1ns/1ps
module feac_validator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cbit_mode = 1'b0;
  logic       msg_stb = 1'b0;
  logic [5:0] msg_code = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] code_out;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  feac_validator uut (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .msg_stb(msg_stb),
    .msg_code(msg_code), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .code_out(code_out), .irq(irq)
  );

  // reference model
  logic [5:0] m_hist [10];
  bit         m_used [10];
  bit m_valid, m_aev, m_aen, m_dev, m_den;
  logic [5:0] m_code;

  function automatic logic [7:0] m_reg();
    return {3'b000, m_valid, m_den, m_dev, m_aen, m_aev};
  endfunction

  function automatic bit m_irq();
    return (m_aev && m_aen) || (m_dev && m_den);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 10; i++) begin m_hist[i] = '0; m_used[i] = 0; end
    m_valid = 0; m_aev = 0; m_aen = 0; m_dev = 0; m_den = 0; m_code = '0;
  endtask

  // one clock cycle: drive, check read data, model the edge, check result
  task automatic cyc(string req, bit stb, logic [5:0] code, bit rd, bit wr, logic [7:0] wd);
    bit sa, sd;
    int mt, fl;
    logic [5:0] rf;
    @(negedge clk);
    msg_stb = stb; msg_code = code; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    #1;
    if (rd) chk({req, " read"}, reg_rdata, m_reg());
    @(posedge clk);
    sa = 0; sd = 0;
    if (stb && cbit_mode) begin
      for (int i = 9; i > 0; i--) begin m_hist[i] = m_hist[i-1]; m_used[i] = m_used[i-1]; end
      m_hist[0] = code; m_used[0] = 1;
      rf = m_valid ? m_code : code;
      mt = 0; fl = 0;
      for (int i = 0; i < 10; i++) begin
        if (m_used[i]) fl++;
        if (m_used[i] && m_hist[i] == rf) mt++;
      end
      if (m_valid && (fl - mt) >= 3) begin m_valid = 0; sd = 1; end
      else if (!m_valid && mt >= 8) begin m_valid = 1; m_code = code; sa = 1; end
    end
    if (rd) begin m_aev = 0; m_dev = 0; end
    if (sa) m_aev = 1;
    if (sd) m_dev = 1;
    if (wr) begin m_aen = wd[1]; m_den = wd[3]; end
    #1;
    msg_stb = 0; reg_rd = 0; reg_wr = 0;
    chk(req, reg_rdata, m_reg());
    chk({req, " code"}, {2'b00, code_out}, {2'b00, m_code});
    chk({req, " irq"}, {7'd0, irq}, {7'd0, m_irq()});
  endtask

  task automatic send(string req, logic [5:0] code);
    cyc(req, 1, code, 0, 0, 8'h00);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset", reg_rdata, 8'h00);
    chk("R10 reset code", {2'b00, code_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // mode off: strobes ignored
    for (int i = 0; i < 10; i++) send("R9", 6'd5);
    cbit_mode = 1'b1;
    cyc("R10 write ignored bits", 0, 0, 0, 1, 8'hFF);
    cyc("R8 enables", 0, 0, 0, 1, 8'h0A);
    // empty slots match nothing, including code 0
    send("R3", 6'd0);
    for (int i = 0; i < 7; i++) send("R1 below", 6'd5);
    chk("R1 seven not valid", {7'd0, reg_rdata[4]}, 8'd0);
    send("R1 R5 eighth", 6'd5);
    chk("R1 valid", {7'd0, reg_rdata[4]}, 8'd1);
    chk("R8 irq on accept", {7'd0, irq}, 8'd1);
    cyc("R7 read clears", 0, 0, 1, 0, 8'h00);
    send("R2 one miss", 6'd9);
    send("R2 two misses", 6'd9);
    chk("R2 kept", {7'd0, reg_rdata[4]}, 8'd1);
    send("R2 R6 third miss", 6'd9);
    chk("R2 dropped", {7'd0, reg_rdata[4]}, 8'd0);
    chk("R4 code kept", {2'b00, code_out}, 8'd5);
    for (int i = 0; i < 4; i++) send("R1 rebuild", 6'd9);
    cyc("R7 set wins", 1, 6'd9, 1, 0, 8'h00);
    chk("R7 acc ev", {7'd0, reg_rdata[0]}, 8'd1);
    chk("R4 new code", {2'b00, code_out}, 8'd9);
    cyc("R8 mask", 0, 0, 0, 1, 8'h00);
    chk("R8 masked irq", {7'd0, irq}, 8'd0);

    // seeded random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [5:0] c;
      r = $urandom_range(0, 99);
      c = (r < 45) ? 6'd12 : (r < 80) ? 6'd33 : 6'($urandom_range(0, 63));
      cbit_mode = ($urandom_range(0, 9) != 0);
      cyc("R1 R2 R7 R8 rnd", $urandom_range(0, 3) != 0, c,
          $urandom_range(0, 5) == 0, $urandom_range(0, 9) == 0, 8'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule